// File: doc/BRIEF.md
# JTAG Scan-Chain Register Access Port

This block sits behind a JTAG TAP controller and gives a debugger read and write access to a 128-entry, 32-bit register space in a peripheral. It receives the TAP's capture, shift and update strobes and the active instruction code. It keeps two data registers of its own. The first is a 5-bit chain-select register, reached with instruction 0x2. The second is a 40-bit access chain, reached with instruction 0xC, but only while the chain-select register holds chain 0. For every other combination of instruction and selected chain, the block acts as a 1-bit bypass register.

Each scan of the access chain carries a command: a data word, a register address and a direction bit. At update time the block turns that command into a one-cycle write or read strobe on a simple register bus. A read result is not returned in the same scan. It is held inside the block and loaded into the data field at the next capture, so it shifts out during the following scan. A debugger therefore reads a burst by pipelining: each scan returns the value requested by the scan before it. The burst ends with a read of register 0, so that a data register with read side effects is not read one extra time.

The whole block runs on TCK. Reset is the synchronous, active-high test-logic reset.

Top module: `scan_reg_port`

## Requirements
- R1: At reset the following all become zero: the access chain, the select shift register, both bus strobes and the held read value. The chain-select register becomes all ones, which means no chain is selected, so a scan under instruction 0xC passes through the bypass bit.
- R2: The access chain is 40 bits and is shifted least significant bit first, from `tdi` towards `tdo`. Bits 31:0 are the data field, bits 38:32 are the register address, and bit 39 is the direction, where 1 means write. `tdo` always shows bit 0 of the register currently selected.
- R3: An update with the chain active and bit 39 set raises `bus_we` for exactly the one cycle after the update edge. During that cycle `bus_addr` carries bits 38:32 and `bus_wdata` carries bits 31:0.
- R4: An update with the chain active and bit 39 clear raises `bus_re` for exactly the one cycle after the update edge, with `bus_addr` set from bits 38:32. `bus_rdata` is sampled during that cycle. At the next capture, the sampled value is loaded into bits 31:0 of the access chain and bits 39:32 are loaded as zero.
- R5: The held read value changes only when a read completes. Captures after a write, or after an inactive scan, return the last read value again. A burst of N reads of a side-effecting register that ends with a read of register 0 accesses that register exactly N times.
- R6: Under instruction 0x2 the 5-bit select shift register is in the scan path. At capture it loads the current chain-select value, and at update it loads the chain-select register. The chain-select register changes at no other time.
- R7: When the instruction is neither 0x2 nor 0xC with chain 0 selected, the block raises no bus strobe. The scan path is then a single bypass bit that captures 0, so the output stream is the input stream delayed by one bit.
- R8: `bus_we` and `bus_re` are never high together, and each update produces at most one strobe, lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock (TCK) |
| rst | input | 1 | Synchronous active-high test-logic reset |
| ir_code | input | 4 | Active instruction from the TAP |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the selected register |
| bus_addr | output | 7 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 32 | Read data, valid while `bus_re` is high |

## Verification
The bus strobes, address and write data become valid in the first cycle after the edge that samples `update_dr`. The read value is sampled at the edge that ends that strobe cycle. It reaches `tdo` only in the scan after the next capture, one bit per shift cycle, and a bypass bit leaves one cycle after it enters. The bench's behavioural model advances at each rising edge, and its expectations are compared with the outputs at the middle of the following low phase. The directed scans add an idle cycle after every update, so each read result is collected only by the next scan, and write effects are checked in the peripheral memory after that idle cycle.

// File: rtl/scan_reg_port_pkg.sv
package scan_reg_port_pkg;
  // Which data register currently feeds the serial output
  typedef enum logic [1:0] {
    SRC_BYPASS = 2'd0,
    SRC_SELECT = 2'd1,
    SRC_ACCESS = 2'd2
  } tdo_src_e;
endpackage

// File: rtl/srp_dr.sv
// Generic JTAG data register: parallel capture, LSB-first shift.
module srp_dr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         capture,
  input  logic         shift,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);
  logic [W-1:0] shifted;

  generate
    if (W == 1) begin : g_single
      assign shifted = tdi;
    end else begin : g_multi
      assign shifted = {tdi, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en && capture) begin
      q <= cap_val;
    end else if (en && shift) begin
      q <= shifted;
    end
  end
endmodule

// File: rtl/srp_chain_select.sv
// Holds the selected chain number and decodes which data register is live.
module srp_chain_select #(
  parameter int               SEL_W     = 5,
  parameter int               IR_W      = 4,
  parameter logic [IR_W-1:0]  SEL_IR    = 4'h2,
  parameter logic [IR_W-1:0]  ACCESS_IR = 4'hC,
  parameter logic [SEL_W-1:0] CHAIN_ID  = '0,
  parameter logic [SEL_W-1:0] SEL_RST   = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IR_W-1:0]  ir_code,
  input  logic             update_dr,
  input  logic [SEL_W-1:0] sel_shift,
  output logic [SEL_W-1:0] chain_sel,
  output logic             is_sel,
  output logic             access_on
);
  assign is_sel    = (ir_code == SEL_IR);
  assign access_on = (ir_code == ACCESS_IR) && (chain_sel == CHAIN_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_sel <= SEL_RST;
    end else if (update_dr && is_sel) begin
      chain_sel <= sel_shift;
    end
  end

  AST_SEL_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !(update_dr && (ir_code == SEL_IR)) |=> $stable(chain_sel)); // R6
endmodule

// File: rtl/srp_bus_ctrl.sv
// Turns an updated command word into bus strobes and keeps the last read value.
module srp_bus_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          go,
  input  logic [DATA_W+ADDR_W:0]        cmd_word,
  input  logic [DATA_W-1:0]             bus_rdata,
  output logic [ADDR_W-1:0]             bus_addr,
  output logic [DATA_W-1:0]             bus_wdata,
  output logic                          bus_we,
  output logic                          bus_re,
  output logic [DATA_W-1:0]             rd_hold
);
  localparam int CHAIN_W = DATA_W + ADDR_W + 1;
  localparam int DIR_BIT = CHAIN_W - 1;

  logic                is_write;
  logic [ADDR_W-1:0]   cmd_addr;
  logic [DATA_W-1:0]   cmd_data;

  assign is_write = cmd_word[DIR_BIT];
  assign cmd_addr = cmd_word[DIR_BIT-1:DATA_W];
  assign cmd_data = cmd_word[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_we <= go && is_write;
      bus_re <= go && !is_write;
      if (go) begin
        bus_addr  <= cmd_addr;
        bus_wdata <= cmd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hold <= '0;
    end else if (bus_re) begin
      rd_hold <= bus_rdata;
    end
  end

  AST_HOLD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(rd_hold)); // R5
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
  import scan_reg_port_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               ADDR_W    = 7,
  parameter int               SEL_W     = 5,
  parameter int               IR_W      = 4,
  parameter logic [IR_W-1:0]  SEL_IR    = 4'h2,
  parameter logic [IR_W-1:0]  ACCESS_IR = 4'hC,
  parameter logic [SEL_W-1:0] CHAIN_ID  = '0,
  parameter logic [SEL_W-1:0] SEL_RST   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int CHAIN_W = DATA_W + ADDR_W + 1;

  logic [SEL_W-1:0]   chain_sel;
  logic [SEL_W-1:0]   sel_q;
  logic [CHAIN_W-1:0] acc_q;
  logic [CHAIN_W-1:0] acc_cap;
  logic [0:0]         byp_q;
  logic [DATA_W-1:0]  rd_hold;
  logic               is_sel;
  logic               access_on;
  logic               byp_on;
  tdo_src_e           src;

  srp_chain_select #(
    .SEL_W(SEL_W), .IR_W(IR_W), .SEL_IR(SEL_IR), .ACCESS_IR(ACCESS_IR),
    .CHAIN_ID(CHAIN_ID), .SEL_RST(SEL_RST)
  ) u_select (
    .clk(clk), .rst(rst), .ir_code(ir_code), .update_dr(update_dr),
    .sel_shift(sel_q), .chain_sel(chain_sel), .is_sel(is_sel),
    .access_on(access_on)
  );

  assign byp_on  = !is_sel && !access_on;
  assign acc_cap = {{(ADDR_W + 1){1'b0}}, rd_hold};

  srp_dr #(.W(SEL_W)) u_sel_dr (
    .clk(clk), .rst(rst), .en(is_sel), .capture(capture_dr),
    .shift(shift_dr), .tdi(tdi), .cap_val(chain_sel), .q(sel_q)
  );

  srp_dr #(.W(CHAIN_W)) u_acc_dr (
    .clk(clk), .rst(rst), .en(access_on), .capture(capture_dr),
    .shift(shift_dr), .tdi(tdi), .cap_val(acc_cap), .q(acc_q)
  );

  srp_dr #(.W(1)) u_byp_dr (
    .clk(clk), .rst(rst), .en(byp_on), .capture(capture_dr),
    .shift(shift_dr), .tdi(tdi), .cap_val(1'b0), .q(byp_q)
  );

  srp_bus_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .go(update_dr && access_on), .cmd_word(acc_q),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .rd_hold(rd_hold)
  );

  always_comb begin
    if (access_on)   src = SRC_ACCESS;
    else if (is_sel) src = SRC_SELECT;
    else             src = SRC_BYPASS;
  end

  always_comb begin
    case (src)
      SRC_ACCESS: tdo = acc_q[0];
      SRC_SELECT: tdo = sel_q[0];
      default:    tdo = byp_q[0];
    endcase
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re)); // R8
  AST_WE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> ($past(update_dr) && $past(ir_code) == ACCESS_IR)); // R3
  AST_RE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (rst)
    bus_re |-> ($past(update_dr) && $past(ir_code) == ACCESS_IR)); // R4
  AST_NO_ACCESS_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    (update_dr && !access_on) |=> (!bus_we && !bus_re)); // R7
endmodule

// File: tb/scan_reg_port_test.sv
`timescale 1ns/1ps
module scan_reg_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ir_code = 4'hC;
  logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic        tdo, bus_we, bus_re;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0, failures = 0;
  bit started = 1'b0, finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  scan_reg_port uut (
    .clk(clk), .rst(rst), .ir_code(ir_code), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  // Peripheral: plain memory plus a read-counting register at address 9
  logic [31:0] mem [128];
  logic [31:0] eff = 0;
  function automatic logic [31:0] periph(input logic [6:0] a);
    return (a == 7'd9) ? eff : mem[a];
  endfunction
  function automatic logic [31:0] init_val(input int i);
    return 32'h1000_0000 + i * 32'h0001_0307;
  endfunction
  initial for (int i = 0; i < 128; i++) mem[i] = init_val(i);
  assign bus_rdata = periph(bus_addr);
  always @(posedge clk) begin
    if (bus_we) mem[bus_addr] <= bus_wdata;
    if (bus_re && bus_addr == 7'd9) eff <= eff + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  logic [39:0] m_acc;
  logic [4:0]  m_ssr, m_sel;
  logic        m_byp, m_we, m_re;
  logic [6:0]  m_addr;
  logic [31:0] m_wd, m_hold, n_hold;
  bit          m_act, m_issel;
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_acc = '0; m_ssr = '0; m_sel = 5'h1F; m_byp = 1'b0;
      m_we = 1'b0; m_re = 1'b0; m_addr = '0; m_wd = '0; m_hold = '0;
    end else begin
      m_act   = (ir_code == 4'hC) && (m_sel == 5'd0);
      m_issel = (ir_code == 4'h2);
      n_hold  = m_re ? periph(m_addr) : m_hold;
      m_we = update_dr && m_act && m_acc[39];
      m_re = update_dr && m_act && !m_acc[39];
      if (update_dr && m_act) begin m_addr = m_acc[38:32]; m_wd = m_acc[31:0]; end
      if (update_dr && m_issel) m_sel = m_ssr;
      if (m_act && capture_dr) m_acc = {8'h00, m_hold};
      else if (m_act && shift_dr) m_acc = {tdi, m_acc[39:1]};
      if (m_issel && capture_dr) m_ssr = m_sel;
      else if (m_issel && shift_dr) m_ssr = {tdi, m_ssr[4:1]};
      if (!m_act && !m_issel && capture_dr) m_byp = 1'b0;
      else if (!m_act && !m_issel && shift_dr) m_byp = tdi;
      m_hold = n_hold;
    end
  end

  // Compare in the low phase; also count strobe cycles
  int we_cnt = 0, re_cnt = 0;
  logic m_tdo;
  always @(negedge clk) begin
    #1;
    if (started && !finished) begin
      if ((ir_code == 4'hC) && (m_sel == 5'd0)) m_tdo = m_acc[0];
      else if (ir_code == 4'h2) m_tdo = m_ssr[0];
      else m_tdo = m_byp;
      chk(tdo === m_tdo, "R2 tdo", tdo, m_tdo);
      chk(bus_we === m_we, "R3 bus_we", bus_we, m_we);
      chk(bus_re === m_re, "R4 bus_re", bus_re, m_re);
      chk(!(bus_we && bus_re), "R8 exclusive strobes", {bus_we, bus_re}, 0);
      if (m_we || m_re) chk(bus_addr === m_addr, "R3 bus_addr", bus_addr, m_addr);
      if (m_we) chk(bus_wdata === m_wd, "R3 bus_wdata", bus_wdata, m_wd);
      if (bus_we) we_cnt++;
      if (bus_re) re_cnt++;
    end
  end

  task automatic scan(input int n, input logic [39:0] din, output logic [39:0] dout);
    dout = '0;
    @(negedge clk); capture_dr = 1'b1;
    @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      #1 dout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 1'b0; tdi = 1'b0; update_dr = 1'b1;
    @(negedge clk); update_dr = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [39:0] cmd(input bit wr, input logic [6:0] a, input logic [31:0] d);
    return {wr, a, d};
  endfunction

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [39:0] d;
  int w0, r0;
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(tdo == 1'b0, "R1 tdo after reset", tdo, 0);
    chk(!bus_we && !bus_re, "R1 strobes after reset", {bus_we, bus_re}, 0);

    // R1/R7: chain 0 not selected after reset, so 0xC scans go through bypass
    w0 = we_cnt;
    scan(40, cmd(1, 7'd3, 32'hDEAD_BEEF), d);
    chk(d == {cmd(1, 7'd3, 32'hDEAD_BEEF)} << 1, "R7 bypass delay", d, cmd(1, 7'd3, 32'hDEAD_BEEF) << 1);
    chk(we_cnt == w0, "R7 no write while unselected", we_cnt, w0);
    chk(mem[3] == init_val(3), "R1 memory untouched", mem[3], init_val(3));

    // R6: select chain 0; capture shows reset select value, then the new one
    ir_code = 4'h2;
    scan(5, 40'd0, d);
    chk(d[4:0] == 5'h1F, "R1 select reset value", d[4:0], 5'h1F);
    scan(5, 40'd0, d);
    chk(d[4:0] == 5'h00, "R6 select readback", d[4:0], 0);

    // R3: write through the chain
    ir_code = 4'hC;
    w0 = we_cnt; r0 = re_cnt;
    scan(40, cmd(1, 7'd3, 32'hA5A5_5A5A), d);
    chk(mem[3] == 32'hA5A5_5A5A, "R3 write data", mem[3], 32'hA5A5_5A5A);
    chk(we_cnt == w0 + 1, "R8 one write strobe", we_cnt, w0 + 1);
    chk(re_cnt == r0, "R3 no read on write", re_cnt, r0);
    for (int k = 0; k < 4; k++) begin
      scan(40, cmd(1, 7'(10 + k), 32'h0F0F_0001 << k), d);
      chk(mem[10 + k] == (32'h0F0F_0001 << k), "R3 write pattern", mem[10 + k], 32'h0F0F_0001 << k);
    end

    // R4/R2: read is returned in the next scan, upper bits zero
    r0 = re_cnt;
    scan(40, cmd(0, 7'd3, 32'hFFFF_FFFF), d);
    chk(re_cnt == r0 + 1, "R8 one read strobe", re_cnt, r0 + 1);
    scan(40, cmd(0, 7'd0, 32'h0), d);
    chk(d[31:0] == 32'hA5A5_5A5A, "R4 read data next scan", d[31:0], 32'hA5A5_5A5A);
    chk(d[39:32] == 8'h00, "R4 upper bits zero", d[39:32], 0);

    // R5: burst on side-effecting register ended with register 0
    scan(40, cmd(0, 7'd9, 32'h0), d);
    scan(40, cmd(0, 7'd9, 32'h0), d);
    chk(d[31:0] == 32'd0, "R5 first burst value", d[31:0], 0);
    scan(40, cmd(0, 7'd0, 32'h0), d);
    chk(d[31:0] == 32'd1, "R5 second burst value", d[31:0], 1);
    chk(eff == 32'd2, "R5 side-effect count", eff, 2);
    scan(40, cmd(1, 7'd4, 32'h1234_5678), d);
    chk(d[31:0] == init_val(0), "R5 hold after read", d[31:0], init_val(0));
    scan(40, cmd(1, 7'd4, 32'h8765_4321), d);
    chk(d[31:0] == init_val(0), "R5 hold across writes", d[31:0], init_val(0));

    // R6/R7: another chain selected blocks bus access
    ir_code = 4'h2;
    scan(5, 40'd3, d);
    ir_code = 4'hC;
    w0 = we_cnt;
    scan(40, cmd(1, 7'd5, 32'hCAFE_F00D), d);
    chk(we_cnt == w0, "R6 no access on other chain", we_cnt, w0);
    chk(mem[5] == init_val(5), "R7 memory untouched", mem[5], init_val(5));
    chk(d == cmd(1, 7'd5, 32'hCAFE_F00D) << 1, "R7 bypass on other chain", d, cmd(1, 7'd5, 32'hCAFE_F00D) << 1);

    // R1: reset in mid-run returns select to all ones
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    ir_code = 4'h2;
    scan(5, 40'd0, d);
    chk(d[4:0] == 5'h1F, "R1 select after second reset", d[4:0], 5'h1F);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule